// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequence Generator

This block turns a stream of step strobes into the logic-level coil waveforms for a four-phase stepper motor. Each strobe moves the pattern one entry forward or backward, depending on a direction bit. Three drive formats are available: single-coil (wave), dual-coil (two-phase) and half-step. The four coil outputs feed external high-current drivers. Strobe timing, step counting and host register access belong to the surrounding logic. That logic uses the one-cycle `step_done` pulse to count the steps it has issued.

The block keeps a position index in half-step units, 0 to 7. Index 2k energises coil k alone. Index 2k+1 energises coils k and k+1 (mod 4).
- Wave drive uses only the even entries.
- Two-phase drive uses only the odd entries.
- Half-step drive uses all eight entries.

Clockwise means an increasing index. After reset, the first strobe of the first run is a reference step: it places the rotor on a known coil and is not counted. When the run input drops, the outputs are either forced low or hold the last pattern, as selected by `hold_on_stop`.

The controller FSM has four states:
- `ST_IDLE`: reset state, with no position established.
- `ST_ARMED`: running, waiting for the reference strobe.
- `ST_RUN`: running, with the position known.
- `ST_STOP`: stopped, with the position known.

It has these transitions:
- IDLE→ARMED when run rises.
- ARMED→IDLE when run falls.
- ARMED→RUN on the reference strobe.
- RUN→STOP when run falls.
- STOP→RUN when run rises.

Top module: `stepper_seq_gen`

## Requirements
- R1: With `fmt_sel`=00 (wave), every counted step leaves exactly one coil on. Clockwise the order is `coil_out` 0001→0010→0100→1000→0001.
- R2: With `fmt_sel`=01 (two-phase), every counted step leaves exactly two adjacent coils on. Clockwise the order is 0011→0110→1100→1001→0011.
- R3: With `fmt_sel`=10 or 11 (half-step), the index moves by one half-step per strobe. The outputs alternate single-coil and dual-coil entries over an eight-entry cycle, and never more than two coils are on.
- R4: The first accepted strobe after reset is a reference step. It sets `coil_out` to 0001 for clockwise (`dir_ccw`=0) or 1000 for counter-clockwise (`dir_ccw`=1), and it produces no `step_done`.
- R5: The reference step happens only once per reset. The first strobe after a later restart is a counted step taken from the held position.
- R6: A strobe is accepted while `run` is high and a run is active. Each counted step raises `step_done` for exactly one cycle, in the cycle after the strobe. `coil_out` shows the new pattern in that same cycle.
- R7: A change of `dir_ccw` steps the sequence backward from the current index rather than restarting it.
- R8: While stopped, `coil_out` is 0000 if `hold_on_stop`=0 and the last pattern if `hold_on_stop`=1. The bit takes effect immediately.
- R9: `fmt_sel` is sampled only while stopped or idle, and the first strobe after the start uses it. A change during a run has no effect until the next stop.
- R10: Before the reference step, `coil_out` is 0000. Strobes while `run` is low move nothing and produce no `step_done`.
- R11: When the index is not on an entry of the active format, the next step moves one half-step, in the step direction, onto the nearest valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Motor run enable; low means stopped |
| step_stb | input | 1 | One-cycle step request |
| dir_ccw | input | 1 | 0 clockwise, 1 counter-clockwise |
| fmt_sel | input | 2 | Drive format: 00 wave, 01 two-phase, 1x half-step |
| hold_on_stop | input | 1 | 1 holds the last pattern while stopped, 0 forces zero |
| coil_out | output | PHASES | Coil drive levels, bit k is coil k |
| step_done | output | 1 | One-cycle pulse per counted step |

## Verification
The bench builds the block with its default `PHASES`=4, which gives an eight-entry half-step index. With four phases, every wrap of the index from 7 to 0 and from 0 to 7 can be reached within a few strobes. So can both reference coils and every format transition between even and odd entries. The directed scenarios move the index onto positions that belong to one format and then switch formats, so the realignment rule is exercised in both directions.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_STOP  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        FMT_WAVE = 2'd0,
        FMT_DUAL = 2'd1,
        FMT_HALF = 2'd2
    } drive_fmt_e;

    function automatic drive_fmt_e decode_fmt(input logic [1:0] sel);
        unique case (sel)
            2'b00:   decode_fmt = FMT_WAVE;
            2'b01:   decode_fmt = FMT_DUAL;
            default: decode_fmt = FMT_HALF;
        endcase
    endfunction

endpackage

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import stepper_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       step_stb,
    output seq_state_e state,
    output logic       accept,
    output logic       load_ref,
    output logic       advance,
    output logic       show_run,
    output logic       sample_fmt,
    output logic       done_q
);

    seq_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!run)          nxt = ST_IDLE;
                else if (step_stb) nxt = ST_RUN;
            end
            ST_RUN:   if (!run) nxt = ST_STOP;
            ST_STOP:  if (run)  nxt = ST_RUN;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        load_ref   = 1'b0;
        advance    = 1'b0;
        show_run   = 1'b0;
        sample_fmt = 1'b0;
        unique case (state)
            ST_IDLE:  sample_fmt = 1'b1;
            ST_ARMED: begin
                accept   = run && step_stb;
                load_ref = accept;
            end
            ST_RUN: begin
                accept   = run && step_stb;
                advance  = accept;
                show_run = 1'b1;
            end
            ST_STOP:  sample_fmt = 1'b1;
            default:  sample_fmt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= advance;
        end
    end

endmodule

// File: rtl/seq_index.sv
module seq_index
    import stepper_seq_pkg::*;
#(
    parameter int PHASES = 4,
    localparam int SEQ_LEN = 2 * PHASES,
    localparam int IDX_W = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ref,
    input  logic             advance,
    input  logic             ccw,
    input  drive_fmt_e       fmt,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST    = IDX_W'(SEQ_LEN - 1);
    localparam logic [IDX_W-1:0] REF_CW  = '0;
    localparam logic [IDX_W-1:0] REF_CCW = IDX_W'(2 * (PHASES - 1));

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
        wrap_inc = (v == LAST) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] wrap_dec(input logic [IDX_W-1:0] v);
        wrap_dec = (v == '0) ? LAST : v - 1'b1;
    endfunction

    logic [IDX_W-1:0] step1, step2, nxt_idx;
    logic             want_odd;

    always_comb begin
        step1    = ccw ? wrap_dec(idx) : wrap_inc(idx);
        step2    = ccw ? wrap_dec(step1) : wrap_inc(step1);
        want_odd = (fmt == FMT_DUAL);
        if (fmt == FMT_HALF) begin
            nxt_idx = step1;
        end else if (step1[0] == want_odd) begin
            nxt_idx = step1;
        end else begin
            nxt_idx = step2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= REF_CW;
        end else if (load_ref) begin
            idx <= ccw ? REF_CCW : REF_CW;
        end else if (advance) begin
            idx <= nxt_idx;
        end
    end

endmodule

// File: rtl/coil_decode.sv
module coil_decode #(
    parameter int PHASES = 4,
    localparam int SEQ_LEN = 2 * PHASES,
    localparam int IDX_W = $clog2(SEQ_LEN)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [PHASES-1:0] pattern
);

    // even index 2k: coil k alone; odd index 2k+1: coils k and k+1
    for (genvar c = 0; c < PHASES; c++) begin : g_coil
        localparam int PREV = (c + PHASES - 1) % PHASES;
        assign pattern[c] = (idx == IDX_W'(2 * c))
                         || (idx == IDX_W'(2 * c + 1))
                         || (idx == IDX_W'(2 * PREV + 1));
    end

endmodule

// File: rtl/stepper_seq_gen.sv
module stepper_seq_gen
    import stepper_seq_pkg::*;
#(
    parameter int PHASES = 4,
    localparam int SEQ_LEN = 2 * PHASES,
    localparam int IDX_W = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step_stb,
    input  logic              dir_ccw,
    input  logic [1:0]        fmt_sel,
    input  logic              hold_on_stop,
    output logic [PHASES-1:0] coil_out,
    output logic              step_done
);

    seq_state_e        fsm_state;
    drive_fmt_e        fmt_act;
    logic              accept, load_ref, advance, show_run, sample_fmt, done_q;
    logic [IDX_W-1:0]  idx;
    logic [PHASES-1:0] pattern;

    seq_ctrl_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .step_stb   (step_stb),
        .state      (fsm_state),
        .accept     (accept),
        .load_ref   (load_ref),
        .advance    (advance),
        .show_run   (show_run),
        .sample_fmt (sample_fmt),
        .done_q     (done_q)
    );

    // format register: follows the select while stopped, frozen while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_act <= FMT_WAVE;
        end else if (sample_fmt) begin
            fmt_act <= decode_fmt(fmt_sel);
        end
    end

    seq_index #(.PHASES(PHASES)) i_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ref (load_ref),
        .advance  (advance),
        .ccw      (dir_ccw),
        .fmt      (fmt_act),
        .idx      (idx)
    );

    coil_decode #(.PHASES(PHASES)) i_decode (
        .idx     (idx),
        .pattern (pattern)
    );

    logic show_hold;
    assign show_hold = (fsm_state == ST_STOP) && hold_on_stop;
    assign coil_out  = (show_run || show_hold) ? pattern : '0;
    assign step_done = done_q;

    logic unused_ok;
    assign unused_ok = accept;

endmodule

// File: rtl/stepper_seq_gen_chk.sv
module stepper_seq_gen_chk
    import stepper_seq_pkg::*;
#(
    parameter int PHASES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              step_stb,
    input logic              hold_on_stop,
    input logic [PHASES-1:0] coil_out,
    input logic              step_done,
    input seq_state_e        state,
    input drive_fmt_e        fmt_act
);

    assert_wave_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && fmt_act == FMT_WAVE) |-> $countones(coil_out) == 1);

    assert_dual_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && fmt_act == FMT_DUAL) |-> $countones(coil_out) == 2);

    assert_at_most_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coil_out) <= 2);

    assert_ref_coil_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && run && step_stb) |=>
            (!step_done && (coil_out == PHASES'(1) || coil_out == PHASES'(1) << (PHASES - 1))));

    assert_done_from_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> $past(step_stb && run));

    assert_done_on_run_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run && step_stb) |=> step_done);

    assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !hold_on_stop) |-> coil_out == '0);

    assert_fmt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN)) |-> $stable(fmt_act));

    assert_no_drive_before_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ARMED) |-> (coil_out == '0 && !step_done));

endmodule

bind stepper_seq_gen stepper_seq_gen_chk #(.PHASES(PHASES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .step_stb     (step_stb),
    .hold_on_stop (hold_on_stop),
    .coil_out     (coil_out),
    .step_done    (step_done),
    .state        (fsm_state),
    .fmt_act      (fmt_act)
);

// File: tb/test_stepper_seq_gen.sv
`timescale 1ns/1ps
module test_stepper_seq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       step_stb = 1'b0;
    logic       dir_ccw = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       hold_on_stop = 1'b1;
    logic [3:0] coil_out;
    logic       step_done;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    stepper_seq_gen i_stepper_seq_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .step_stb     (step_stb),
        .dir_ccw      (dir_ccw),
        .fmt_sel      (fmt_sel),
        .hold_on_stop (hold_on_stop),
        .coil_out     (coil_out),
        .step_done    (step_done)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; step_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // strobe one cycle; sample just after the capturing edge
    task automatic pulse(input logic ccw);
        @(negedge clk);
        dir_ccw = ccw;
        step_stb = 1'b1;
        @(posedge clk);
        #1;
        step_stb = 1'b0;
    endtask

    task automatic step_expect(input string req, input logic ccw,
                               input logic [3:0] exp_coil, input logic exp_done);
        pulse(ccw);
        chk(req, coil_out, exp_coil);
        chk({req, " step_done"}, {3'b0, step_done}, {3'b0, exp_done});
    endtask

    task automatic set_run(input logic v);
        @(negedge clk);
        run = v;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(posedge clk); #1;
        chk("R10 reset coil", coil_out, 4'b0000);
        chk("R10 reset done", {3'b0, step_done}, 4'b0);
        pulse(1'b0);
        chk("R10 strobe idle coil", coil_out, 4'b0000);
        chk("R10 strobe idle done", {3'b0, step_done}, 4'b0);
    endtask

    task automatic t_wave_cw();
        fmt_sel = 2'b00; hold_on_stop = 1'b1;
        set_run(1'b1);
        chk("R10 armed coil", coil_out, 4'b0000);
        step_expect("R4 ref cw", 1'b0, 4'b0001, 1'b0);
        step_expect("R1 wave", 1'b0, 4'b0010, 1'b1);
        @(posedge clk); #1;
        chk("R6 done one cycle", {3'b0, step_done}, 4'b0);
        step_expect("R1 wave", 1'b0, 4'b0100, 1'b1);
        step_expect("R1 wave", 1'b0, 4'b1000, 1'b1);
        step_expect("R1 wave wrap", 1'b0, 4'b0001, 1'b1);
    endtask

    task automatic t_reverse();
        step_expect("R7 reverse", 1'b1, 4'b1000, 1'b1);
        step_expect("R7 reverse", 1'b1, 4'b0100, 1'b1);
        step_expect("R7 forward again", 1'b0, 4'b1000, 1'b1);
    endtask

    task automatic t_stop_hold();
        set_run(1'b0);
        hold_on_stop = 1'b1; #1;
        chk("R8 hold", coil_out, 4'b1000);
        hold_on_stop = 1'b0; #1;
        chk("R8 zero", coil_out, 4'b0000);
        hold_on_stop = 1'b1; #1;
        chk("R8 hold live", coil_out, 4'b1000);
        pulse(1'b0);
        chk("R10 strobe stopped coil", coil_out, 4'b1000);
        chk("R10 strobe stopped done", {3'b0, step_done}, 4'b0);
    endtask

    task automatic t_dual_restart();
        fmt_sel = 2'b01;
        set_run(1'b1);
        step_expect("R5 R11 R9 restart dual", 1'b0, 4'b1001, 1'b1);
        step_expect("R2 dual", 1'b0, 4'b0011, 1'b1);
        step_expect("R2 dual", 1'b0, 4'b0110, 1'b1);
        step_expect("R2 dual", 1'b0, 4'b1100, 1'b1);
        step_expect("R2 dual", 1'b0, 4'b1001, 1'b1);
    endtask

    task automatic t_fmt_while_running();
        @(negedge clk); fmt_sel = 2'b00;
        step_expect("R9 change ignored", 1'b0, 4'b0011, 1'b1);
        set_run(1'b0);
        set_run(1'b1);
        step_expect("R9 R11 wave after stop", 1'b0, 4'b0010, 1'b1);
    endtask

    task automatic t_half();
        set_run(1'b0);
        fmt_sel = 2'b10;
        set_run(1'b1);
        step_expect("R3 half", 1'b0, 4'b0110, 1'b1);
        step_expect("R3 half", 1'b0, 4'b0100, 1'b1);
        step_expect("R3 half", 1'b0, 4'b1100, 1'b1);
        step_expect("R3 half", 1'b0, 4'b1000, 1'b1);
        step_expect("R3 half", 1'b0, 4'b1001, 1'b1);
        step_expect("R3 half wrap", 1'b0, 4'b0001, 1'b1);
        step_expect("R3 half", 1'b0, 4'b0011, 1'b1);
        step_expect("R3 half", 1'b0, 4'b0010, 1'b1);
        step_expect("R3 half back", 1'b1, 4'b0011, 1'b1);
    endtask

    task automatic t_ref_ccw();
        do_reset();
        fmt_sel = 2'b00;
        set_run(1'b1);
        step_expect("R4 ref ccw", 1'b1, 4'b1000, 1'b0);
        step_expect("R1 wave ccw", 1'b1, 4'b0100, 1'b1);
        fmt_sel = 2'b11;
        set_run(1'b0);
        set_run(1'b1);
        step_expect("R3 fmt 11 half", 1'b1, 4'b0110, 1'b1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_wave_cw();
        t_reverse();
        t_stop_hold();
        t_dual_restart();
        t_fmt_while_running();
        t_half();
        t_ref_ccw();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule